// File: doc/BRIEF.md
# Modem Status Loopback Logic

This block produces the 8-bit modem status value of a serial port from the modem control value that software writes. No real modem pins exist. In normal operation the carrier-detect and data-set-ready lines read as permanently asserted, and clear-to-send and ring read as deasserted. When the control value has its loopback bit set, the four control outputs are folded back onto the four status lines.

Every control write compares the status lines before and after the write. A line that changed raises a sticky change flag in the low half of the status value. Ring is the exception: its flag is raised only by a falling edge. A status read presents the current value and then clears all four change flags. A single flag output, the OR of the change flags, feeds the port's interrupt logic.

The block keeps a registered copy of the last control value written, and the status lines are derived from that copy. Strobes are single-cycle and sampled on the rising clock edge. Results appear on the outputs after that edge.

Top module: `modem_status_loop`

## Requirements
- R1: With control bit 4 (loopback) set, status bit 4 follows control bit 1, bit 5 follows control bit 0, bit 6 follows control bit 2, and bit 7 follows control bit 3.
- R2: With control bit 4 clear, status bits 7:4 read 4'b1010: bit 7 and bit 5 are high, bit 6 and bit 4 are low.
- R3: A control write that changes status bit 4, 5 or 7 sets change flag bit 0, 1 or 3 respectively.
- R4: Change flag bit 2 is set by a control write only when status bit 6 goes from 1 to 0. A rising bit 6 sets no flag.
- R5: Change flags stay set across later writes until a read. A write replaces bits 7:4 with the lines of the new control value. With no write, bits 7:4 hold.
- R6: A read strobe leaves the output unchanged during its own cycle and clears bits 3:0 from the next cycle on.
- R7: When a read and a write share a cycle, flags from before the read are cleared, but flags raised by that write are kept.
- R8: Reset clears the stored control copy and the change flags, so the status reads 8'hA0 with the flag output low. Assertion of reset acts at once.
- R9: The flag output is high exactly when any of status bits 3:0 is high.
- R10: Control bits 7:5 have no effect on the status value.
- R11: The effect of a strobe is visible on the outputs in the first cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_in_i | input | 8 | Control value carried by a write |
| ctrl_wr_i | input | 1 | Control write strobe, one cycle |
| stat_rd_i | input | 1 | Status read strobe, one cycle |
| stat_o | output | 8 | Status value: 7:4 lines, 3:0 change flags |
| delta_any_o | output | 1 | OR of the change flags |

## Verification
All state sits in registers that a strobe updates on one clock edge, and both outputs decode those registers combinationally. Every result is therefore due one cycle after the strobe is sampled. The bench drives strobes on the falling edge and compares outputs at the following falling edge, half a cycle after the updating rising edge. For read strobes it also samples in the strobe's own cycle, before the edge, to confirm the returned value is still the old one. The only result not tied to a clock edge is reset assertion, which is checked a few nanoseconds after reset falls.

// File: rtl/msl_pkg.sv
package msl_pkg;
  localparam int LINE_N = 4;
  localparam int CTRL_USED = 5;

  // control bits, index order matters: bit 0 at the bottom
  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } ctrl_t;

  // status lines as they sit in status bits 7:4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } line_t;

  // change flags as they sit in status bits 3:0
  typedef struct packed {
    logic ddcd;
    logic teri;
    logic ddsr;
    logic dcts;
  } delta_t;
endpackage

// File: rtl/msl_rst_sync.sv
module msl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/msl_line_map.sv
module msl_line_map
  import msl_pkg::*;
(
  input  ctrl_t ctrl_i,
  output line_t line_o
);
  always_comb begin
    if (ctrl_i.loop) begin
      line_o.cts = ctrl_i.rts;
      line_o.dsr = ctrl_i.dtr;
      line_o.ri  = ctrl_i.out1;
      line_o.dcd = ctrl_i.out2;
    end else begin
      line_o.cts = 1'b0;
      line_o.dsr = 1'b1;
      line_o.ri  = 1'b0;
      line_o.dcd = 1'b1;
    end
  end
endmodule

// File: rtl/msl_delta_detect.sv
module msl_delta_detect
  import msl_pkg::*;
(
  input  line_t  old_i,
  input  line_t  new_i,
  output delta_t set_o
);
  logic [LINE_N-1:0] diff;

  assign diff = old_i ^ new_i;

  // level-change flags share the line's bit position; ring uses a falling edge
  generate
    for (genvar b = 0; b < LINE_N; b++) begin : g_flag
      if (b == 2) begin : g_trail
        assign set_o[b] = old_i[b] & ~new_i[b];
      end else begin : g_level
        assign set_o[b] = diff[b];
      end
    end
  endgenerate
endmodule

// File: rtl/msl_status_reg.sv
module msl_status_reg
  import msl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_i,
  input  logic   rd_i,
  input  ctrl_t  ctrl_new_i,
  input  delta_t set_i,
  output ctrl_t  ctrl_q,
  output delta_t delta_q
);
  ctrl_t  ctrl_d;
  delta_t delta_d;
  delta_t kept;

  always_comb begin
    ctrl_d  = ctrl_q;
    kept    = rd_i ? delta_t'('0) : delta_q;
    delta_d = kept;
    if (wr_i) begin
      ctrl_d  = ctrl_new_i;
      delta_d = kept | set_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      delta_q <= '0;
    end else begin
      if (wr_i)        ctrl_q  <= ctrl_d;
      if (wr_i | rd_i) delta_q <= delta_d;
    end
  end

  // R5
  delta_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i) |=> (delta_q == '0));

  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_q));
endmodule

// File: rtl/modem_status_loop.sv
module modem_status_loop
  import msl_pkg::*;
#(
  parameter int CTRL_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_in_i,
  input  logic              ctrl_wr_i,
  input  logic              stat_rd_i,
  output logic [2*LINE_N-1:0] stat_o,
  output logic              delta_any_o
);
  logic   rst_sync_n;
  ctrl_t  ctrl_new;
  ctrl_t  ctrl_q;
  line_t  line_cur;
  line_t  line_new;
  delta_t set_mask;
  delta_t delta_q;
  logic   unused_hi;

  assign ctrl_new  = ctrl_t'(ctrl_in_i[CTRL_USED-1:0]);
  assign unused_hi = ^ctrl_in_i[CTRL_W-1:CTRL_USED];

  msl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  msl_line_map u_map_cur (.ctrl_i(ctrl_q),   .line_o(line_cur));
  msl_line_map u_map_new (.ctrl_i(ctrl_new), .line_o(line_new));

  msl_delta_detect u_det (
    .old_i (line_cur),
    .new_i (line_new),
    .set_o (set_mask)
  );

  msl_status_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_i       (ctrl_wr_i),
    .rd_i       (stat_rd_i),
    .ctrl_new_i (ctrl_new),
    .set_i      (set_mask),
    .ctrl_q     (ctrl_q),
    .delta_q    (delta_q)
  );

  assign stat_o      = {line_cur, delta_q};
  assign delta_any_o = |delta_q;

  // R1
  loop_map_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_wr_i && ctrl_in_i[4]) |=>
      (stat_o[7:4] == {$past(ctrl_in_i[3]), $past(ctrl_in_i[2]),
                       $past(ctrl_in_i[0]), $past(ctrl_in_i[1])}));

  // R2
  nonloop_lines_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_wr_i && !ctrl_in_i[4]) |=> (stat_o[7:4] == 4'b1010));

  // R4
  teri_edge_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(stat_o[2]) |-> ($past(ctrl_wr_i) && $past(stat_o[6]) && !stat_o[6]));

  // R9
  any_fall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(delta_any_o) |-> $past(stat_rd_i));
endmodule

// File: tb/tb_modem_status_loop.sv
module tb_modem_status_loop;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl_in = 8'h00;
  logic       ctrl_wr = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] stat;
  logic       delta_any;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  modem_status_loop dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_in_i   (ctrl_in),
    .ctrl_wr_i   (ctrl_wr),
    .stat_rd_i   (stat_rd),
    .stat_o      (stat),
    .delta_any_o (delta_any)
  );

  // vector: {wr, rd, ctrl[7:0], expected status after the edge[7:0], tag[3:0]}
  localparam int NV = 17;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h00, 8'hA0, 4'd2},
    {1'b1, 1'b0, 8'h10, 8'h0A, 4'd3},
    {1'b0, 1'b1, 8'h00, 8'h00, 4'd6},
    {1'b1, 1'b0, 8'h12, 8'h11, 4'd1},
    {1'b1, 1'b0, 8'h16, 8'h51, 4'd4},
    {1'b0, 1'b1, 8'h00, 8'h50, 4'd6},
    {1'b1, 1'b0, 8'h12, 8'h14, 4'd4},
    {1'b1, 1'b0, 8'h1F, 8'hFE, 4'd5},
    {1'b1, 1'b1, 8'h1D, 8'hE1, 4'd7},
    {1'b1, 1'b0, 8'hF9, 8'hA5, 4'd10},
    {1'b0, 1'b0, 8'h00, 8'hA5, 4'd5},
    {1'b1, 1'b0, 8'h00, 8'hA5, 4'd5},
    {1'b0, 1'b1, 8'h00, 8'hA0, 4'd6},
    {1'b1, 1'b0, 8'h0F, 8'hA0, 4'd2},
    {1'b1, 1'b0, 8'h14, 8'h4A, 4'd3},
    {1'b1, 1'b0, 8'h00, 8'hAE, 4'd4},
    {1'b0, 1'b1, 8'h00, 8'hA0, 4'd11}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd10:   return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_out(input string req, input logic [7:0] exp);
    check(req, stat, exp);
    // R9: flag output follows bits 3:0
    check("R9", {7'd0, delta_any}, {7'd0, |exp[3:0]});
  endtask

  initial begin
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R8", 8'hA0);
    prev = 8'hA0;

    for (int i = 0; i < NV; i++) begin
      ctrl_wr = VEC[i][21];
      stat_rd = VEC[i][20];
      ctrl_in = VEC[i][19:12];
      #1;
      // R6: value during the read's own cycle is the current one
      if (stat_rd) check("R6", stat, prev);
      @(negedge clk);
      ctrl_wr = 1'b0;
      stat_rd = 1'b0;
      // R11: result due one edge after the strobe
      check_out(tag_name(VEC[i][3:0]), VEC[i][11:4]);
      prev = VEC[i][11:4];
    end

    // R5: with no strobe nothing moves over several cycles
    ctrl_in = 8'h1F;
    repeat (3) @(negedge clk);
    check_out("R5", 8'hA0);

    // R8: reset mid-run with flags set
    ctrl_in = 8'h10; ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    check_out("R3", 8'h0A);
    #3 rst_n = 1'b0;
    #2;
    check_out("R8", 8'hA0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R8", 8'hA0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule